// File: doc/BRIEF.md
# I2C Short-Transaction Sequencer

This block drives a byte-level I2C engine through a complete short transfer from a single packed control word, so software does not service every byte. Software loads up to eight transmit bytes into two 32-bit mailbox words, writes the control word, and later collects up to eight received bytes from two 32-bit receive words. Three transfer shapes are supported: a lone write, a lone read, and a write followed by a repeated start and a read. Both 7-bit and 10-bit target addresses are handled.

The sequencer issues one command at a time to the byte engine (start, repeated start, write byte, read byte, stop) and waits for the engine's done pulse before moving on. A missing acknowledge on any address or write byte ends the transfer with a stop and raises an error flag. Completion, successful or not, sets a cause bit which, with its mask bit, drives the interrupt output.

Register map (word index on `reg_addr_i`): 0 control, 1 transmit low, 2 transmit high, 3 receive low, 4 receive high, 5 status, 6 cause, 7 mask.

Top module: `i2c_txgen`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `eng_req_o` is low.
- R2: A control write with bit19 (enable) set and bit0 (write) or bit1 (read) set, while idle, launches a transfer whose first engine command is start (code 1); while a transfer runs, writes to control and transmit words are ignored and each command is held until `eng_done_i`.
- R3: The first address byte is {addr[6:0], dir} for 7-bit targets; with bit12 set it is {5'b11110, addr[9:8], dir} followed by addr[7:0]; addr sits in control bits 11:2 and dir is 1 only for a read-only transfer.
- R4: A write sends (control bits 15:13)+1 data bytes with write command code 3, byte k taken from the 64-bit value {tx high, tx low} at bits 8k+7:8k.
- R5: A read issues (control bits 18:16)+1 read commands (code 4); received byte k lands in {rx high, rx low} at bits 8k+7:8k, bytes not received read zero, the last read has `eng_last_o` set and is followed by stop (code 5).
- R6: With bits 0, 1 and 20 set, the write phase is followed by a repeated start (code 2), the address byte with dir 1, then the read phase; with bits 0 and 1 but not 20, only the write phase runs.
- R7: A missing acknowledge on an address or write byte ends the transfer with stop at once and sets status bit0; a successful transfer leaves status bit0 clear.
- R8: Completion sets cause bit0 after the stop is done; any write to the cause word clears it; `irq_o` is high exactly when cause bit0 and mask bit0 are both set.
- R9: The control word keeps its value after completion and is cleared by writing zero; an idle control write without bit19 is stored but starts nothing.
- R10: Control bits 31:21 read zero; launching clears both receive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| eng_req_o | output | 1 | Command valid to byte engine |
| eng_cmd_o | output | 3 | Command code: 1 start, 2 repeated start, 3 write, 4 read, 5 stop |
| eng_wdata_o | output | 8 | Byte to send for a write command |
| eng_last_o | output | 1 | Read byte is the last, answer with NACK |
| eng_done_i | input | 1 | One-cycle pulse, command complete |
| eng_ack_i | input | 1 | Target acknowledged the written byte (valid with done) |
| eng_rdata_i | input | 8 | Received byte (valid with done on a read) |

## Verification
The assertions assume the byte engine behaves as a proper handshake partner: `eng_done_i` pulses for one cycle only while a command is pending, and `eng_ack_i` and `eng_rdata_i` are meaningful only with that pulse. The bench's engine model raises done at most once per observed request, waits a cycle between commands, and never pulses done while idle. Software-side inputs are kept legal by launching only from idle with lengths inside the three-bit fields, and by clearing cause and control between transfers.

// File: rtl/i2c_txgen_pkg.sv
package i2c_txgen_pkg;
  localparam int DW    = 32;
  localparam int MAXB  = 8;
  localparam int LENW  = $clog2(MAXB);
  localparam int CTRLW = 21;
  localparam int RAW   = 3;

  localparam int CB_WR = 0;
  localparam int CB_RD = 1;
  localparam int CB_EN = 19;

  typedef enum logic [2:0] {
    ENG_NONE = 3'd0, ENG_START = 3'd1, ENG_RESTART = 3'd2,
    ENG_WRITE = 3'd3, ENG_READ = 3'd4, ENG_STOP = 3'd5
  } eng_cmd_e;

  typedef enum logic [RAW-1:0] {
    REG_CTRL = 3'd0, REG_TXL = 3'd1, REG_TXH = 3'd2, REG_RXL = 3'd3,
    REG_RXH = 3'd4, REG_STAT = 3'd5, REG_CAUSE = 3'd6, REG_MASK = 3'd7
  } reg_sel_e;

  // packed from bit 20 down to bit 0; software decodes these positions
  typedef struct packed {
    logic            rs;
    logic            en;
    logic [LENW-1:0] rxl;
    logic [LENW-1:0] txl;
    logic            ext;
    logic [9:0]      addr;
    logic            rd;
    logic            wr;
  } ctrl_t;

  function automatic logic [7:0] addr_byte(logic [9:0] a, logic ext, logic dir);
    return ext ? {5'b11110, a[9:8], dir} : {a[6:0], dir};
  endfunction
endpackage

// File: rtl/i2c_txgen_regs.sv
module i2c_txgen_regs
  import i2c_txgen_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RAW-1:0]  addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            busy_i,
  input  logic            launch_i,
  input  logic            rx_we_i,
  input  logic [LENW-1:0] rx_idx_i,
  input  logic [7:0]      rx_byte_i,
  input  logic [LENW-1:0] tx_idx_i,
  input  logic            fin_i,
  input  logic            fin_err_i,
  output logic [DW-1:0]   rdata_o,
  output ctrl_t           ctrl_o,
  output logic [7:0]      tx_byte_o,
  output logic            cause_o,
  output logic            mask_o
);
  localparam int TXW = 2 * DW;

  ctrl_t          ctrl_q;
  logic [TXW-1:0] tx_q;
  logic [7:0]     rx_b [MAXB];
  logic [TXW-1:0] rx_flat;
  logic           cause_q, mask_q, err_q;
  logic           sw_wr;

  assign sw_wr = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tx_q   <= '0;
    end else if (sw_wr) begin
      case (addr_i)
        REG_CTRL: ctrl_q         <= ctrl_t'(wdata_i[CTRLW-1:0]);
        REG_TXL:  tx_q[DW-1:0]   <= wdata_i;
        REG_TXH:  tx_q[TXW-1:DW] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= 1'b0;
      mask_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (fin_i) cause_q <= 1'b1;
      else if (we_i && addr_i == REG_CAUSE) cause_q <= 1'b0;
      if (we_i && addr_i == REG_MASK) mask_q <= wdata_i[0];
      if (launch_i) err_q <= 1'b0;
      else if (fin_i) err_q <= fin_err_i;
    end
  end

  for (genvar g = 0; g < MAXB; g++) begin : g_rx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rx_b[g] <= '0;
      else if (launch_i) rx_b[g] <= '0;
      else if (rx_we_i && rx_idx_i == LENW'(g)) rx_b[g] <= rx_byte_i;
    end
    assign rx_flat[8*g +: 8] = rx_b[g];
  end

  assign tx_byte_o = tx_q[{tx_idx_i, 3'b000} +: 8];
  assign ctrl_o    = ctrl_q;
  assign cause_o   = cause_q;
  assign mask_o    = mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL:  rdata_o = {{(DW-CTRLW){1'b0}}, ctrl_q};
      REG_TXL:   rdata_o = tx_q[DW-1:0];
      REG_TXH:   rdata_o = tx_q[TXW-1:DW];
      REG_RXL:   rdata_o = rx_flat[DW-1:0];
      REG_RXH:   rdata_o = rx_flat[TXW-1:DW];
      REG_STAT:  rdata_o[0] = err_q;
      REG_CAUSE: rdata_o[0] = cause_q;
      REG_MASK:  rdata_o[0] = mask_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_txgen_seq.sv
module i2c_txgen_seq
  import i2c_txgen_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  ctrl_t           ctrl_i,
  input  logic            eng_done_i,
  input  logic            eng_ack_i,
  input  logic [7:0]      tx_byte_i,
  output logic            eng_req_o,
  output eng_cmd_e        eng_cmd_o,
  output logic [7:0]      eng_wdata_o,
  output logic            eng_last_o,
  output logic [LENW-1:0] idx_o,
  output logic            rx_we_o,
  output logic            fin_o,
  output logic            fin_err_o,
  output logic            busy_o
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR1, ST_ADDR2, ST_WR,
    ST_RSTART, ST_RADDR, ST_RD, ST_STOP
  } st_e;

  st_e             st_q;
  logic [LENW-1:0] idx_q;
  logic            err_q;
  logic            do_rd;

  // read phase needs repeated start when a write precedes it
  assign do_rd = ctrl_i.rd && (!ctrl_i.wr || ctrl_i.rs);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      err_q <= 1'b0;
    end else if (launch_i) begin
      st_q  <= ST_START;
      idx_q <= '0;
      err_q <= 1'b0;
    end else if (eng_done_i && st_q != ST_IDLE) begin
      if (!eng_ack_i && (st_q == ST_ADDR1 || st_q == ST_ADDR2 ||
                         st_q == ST_WR || st_q == ST_RADDR)) begin
        err_q <= 1'b1;
        st_q  <= ST_STOP;
      end else begin
        case (st_q)
          ST_START:  st_q <= ST_ADDR1;
          ST_ADDR1:  st_q <= ctrl_i.ext ? ST_ADDR2 : (ctrl_i.wr ? ST_WR : ST_RD);
          ST_ADDR2:  st_q <= ctrl_i.wr ? ST_WR : ST_RD;
          ST_WR:
            if (idx_q == ctrl_i.txl) begin
              idx_q <= '0;
              st_q  <= do_rd ? ST_RSTART : ST_STOP;
            end else idx_q <= idx_q + 1'b1;
          ST_RSTART: st_q <= ST_RADDR;
          ST_RADDR:  st_q <= ST_RD;
          ST_RD:
            if (idx_q == ctrl_i.rxl) st_q <= ST_STOP;
            else idx_q <= idx_q + 1'b1;
          default:   st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    eng_cmd_o   = ENG_NONE;
    eng_wdata_o = '0;
    case (st_q)
      ST_START:  eng_cmd_o = ENG_START;
      ST_ADDR1: begin
        eng_cmd_o   = ENG_WRITE;
        eng_wdata_o = addr_byte(ctrl_i.addr, ctrl_i.ext, !ctrl_i.wr);
      end
      ST_ADDR2: begin
        eng_cmd_o   = ENG_WRITE;
        eng_wdata_o = ctrl_i.addr[7:0];
      end
      ST_WR: begin
        eng_cmd_o   = ENG_WRITE;
        eng_wdata_o = tx_byte_i;
      end
      ST_RSTART: eng_cmd_o = ENG_RESTART;
      ST_RADDR: begin
        eng_cmd_o   = ENG_WRITE;
        eng_wdata_o = addr_byte(ctrl_i.addr, ctrl_i.ext, 1'b1);
      end
      ST_RD:     eng_cmd_o = ENG_READ;
      ST_STOP:   eng_cmd_o = ENG_STOP;
      default: ;
    endcase
  end

  assign eng_req_o  = st_q != ST_IDLE;
  assign eng_last_o = st_q == ST_RD && idx_q == ctrl_i.rxl;
  assign idx_o      = idx_q;
  assign rx_we_o    = st_q == ST_RD && eng_done_i;
  assign fin_o      = st_q == ST_STOP && eng_done_i;
  assign fin_err_o  = err_q;
  assign busy_o     = st_q != ST_IDLE;
endmodule

// File: rtl/i2c_txgen.sv
module i2c_txgen
  import i2c_txgen_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  output logic          eng_req_o,
  output logic [2:0]    eng_cmd_o,
  output logic [7:0]    eng_wdata_o,
  output logic          eng_last_o,
  input  logic          eng_done_i,
  input  logic          eng_ack_i,
  input  logic [7:0]    eng_rdata_i
);
  ctrl_t           ctrl_w;
  eng_cmd_e        cmd_w;
  logic [7:0]      tx_byte_w;
  logic [LENW-1:0] idx_w;
  logic            busy_w, launch_w, rx_we_w, fin_w, fin_err_w, cause_w, mask_w;

  assign launch_w = reg_we_i && reg_addr_i == REG_CTRL && reg_wdata_i[CB_EN] &&
                    (reg_wdata_i[CB_WR] || reg_wdata_i[CB_RD]) && !busy_w;

  i2c_txgen_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy_w),
    .launch_i  (launch_w),
    .rx_we_i   (rx_we_w),
    .rx_idx_i  (idx_w),
    .rx_byte_i (eng_rdata_i),
    .tx_idx_i  (idx_w),
    .fin_i     (fin_w),
    .fin_err_i (fin_err_w),
    .rdata_o   (reg_rdata_o),
    .ctrl_o    (ctrl_w),
    .tx_byte_o (tx_byte_w),
    .cause_o   (cause_w),
    .mask_o    (mask_w)
  );

  i2c_txgen_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch_w),
    .ctrl_i      (ctrl_w),
    .eng_done_i  (eng_done_i),
    .eng_ack_i   (eng_ack_i),
    .tx_byte_i   (tx_byte_w),
    .eng_req_o   (eng_req_o),
    .eng_cmd_o   (cmd_w),
    .eng_wdata_o (eng_wdata_o),
    .eng_last_o  (eng_last_o),
    .idx_o       (idx_w),
    .rx_we_o     (rx_we_w),
    .fin_o       (fin_w),
    .fin_err_o   (fin_err_w),
    .busy_o      (busy_w)
  );

  assign eng_cmd_o = cmd_w;
  assign irq_o     = cause_w && mask_w;
endmodule

// File: rtl/i2c_txgen_chk.sv
module i2c_txgen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy,
  input logic       cause,
  input logic       eng_req_o,
  input logic [2:0] eng_cmd_o,
  input logic       eng_last_o,
  input logic       eng_done_i,
  input logic       eng_ack_i
);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_cmd_o));

  p_first_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> eng_cmd_o == 3'd1);

  p_last_is_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_last_o |-> eng_cmd_o == 3'd4);

  p_stop_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_done_i && eng_last_o |=> eng_cmd_o == 3'd5);

  p_stop_after_nack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_done_i && eng_cmd_o == 3'd3 && !eng_ack_i |=> eng_cmd_o == 3'd5);

  p_cause_on_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause) |-> $past(eng_req_o && eng_done_i && eng_cmd_o == 3'd5));
endmodule

bind i2c_txgen i2c_txgen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy       (busy_w),
  .cause      (cause_w),
  .eng_req_o  (eng_req_o),
  .eng_cmd_o  (eng_cmd_o),
  .eng_last_o (eng_last_o),
  .eng_done_i (eng_done_i),
  .eng_ack_i  (eng_ack_i)
);

// File: tb/i2c_txgen_tb.sv
module i2c_txgen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        eng_req, eng_last;
  logic [2:0]  eng_cmd;
  logic [7:0]  eng_wdata;
  logic        eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0]  eng_rdata = '0;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  i2c_txgen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .eng_req_o(eng_req), .eng_cmd_o(eng_cmd), .eng_wdata_o(eng_wdata),
    .eng_last_o(eng_last), .eng_done_i(eng_done), .eng_ack_i(eng_ack),
    .eng_rdata_i(eng_rdata)
  );

  // engine model and log
  logic [2:0] log_cmd [32];
  logic [7:0] log_dat [32];
  logic       log_lst [32];
  int log_n = 0, wc_m = 0, rc_m = 0, nack_g = -1;
  logic [7:0] rx_seed = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (eng_req) begin
        if (log_n < 32) begin
          log_cmd[log_n] = eng_cmd; log_dat[log_n] = eng_wdata; log_lst[log_n] = eng_last;
        end
        log_n++;
        eng_ack = 1'b1;
        if (eng_cmd == 3'd3) begin eng_ack = (wc_m != nack_g); wc_m++; end
        if (eng_cmd == 3'd4) begin eng_rdata = rx_seed + 8'(rc_m) * 8'h29; rc_m++; end
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // expected command list
  logic [2:0] exp_cmd [32];
  logic [7:0] exp_dat [32];
  logic       exp_lst [32];
  int en = 0, wc_e = 0;
  bit stopped = 0;

  task automatic push(input logic [2:0] c, input logic [7:0] d, input logic l);
    if (!stopped) begin
      exp_cmd[en] = c; exp_dat[en] = d; exp_lst[en] = l; en++;
      if (c == 3'd3) begin
        if (wc_e == nack_g) stopped = 1;
        wc_e++;
      end
    end
  endtask

  logic mask_g = 1'b1;

  task automatic run_xfer(input string tag, input bit wr, input bit rd, input bit rs,
                          input bit ext, input logic [9:0] addr, input int txn,
                          input int rxn, input int nack, input logic [7:0] seed,
                          input bit poke);
    logic [63:0] tx, rx_exp;
    logic [31:0] ctrl, d, lo, hi;
    bit do_rd, bad;
    int cnt;
    for (int k = 0; k < 8; k++) tx[8*k +: 8] = seed + 8'(k) * 8'h3B;
    wr_reg(3'd1, tx[31:0]);
    wr_reg(3'd2, tx[63:32]);
    log_n = 0; wc_m = 0; rc_m = 0; nack_g = nack; rx_seed = seed ^ 8'hC3;
    ctrl = '0;
    ctrl[0] = wr; ctrl[1] = rd; ctrl[11:2] = addr; ctrl[12] = ext;
    ctrl[15:13] = 3'(txn - 1); ctrl[18:16] = 3'(rxn - 1); ctrl[19] = 1'b1; ctrl[20] = rs;
    wr_reg(3'd0, ctrl);
    if (poke) begin
      repeat (3) @(negedge clk);
      wr_reg(3'd1, ~tx[31:0]);
      wr_reg(3'd0, 32'h0);
    end
    cnt = 0; d = '0;
    while (d[0] !== 1'b1 && cnt < 3000) begin rd_reg(3'd6, d); cnt++; end
    check(d[0] === 1'b1, {tag, " R8 completion cause"}, 64'(d), 64'd1);
    check(irq === mask_g, {tag, " R8 irq vs mask"}, 64'(irq), 64'(mask_g));
    // expected sequence
    en = 0; wc_e = 0; stopped = 0;
    do_rd = rd && (!wr || rs);
    push(3'd1, 8'h0, 1'b0);
    push(3'd3, ext ? {5'b11110, addr[9:8], !wr} : {addr[6:0], !wr}, 1'b0);
    if (ext) push(3'd3, addr[7:0], 1'b0);
    if (wr) for (int k = 0; k < txn; k++) push(3'd3, tx[8*k +: 8], 1'b0);
    if (do_rd) begin
      if (wr) begin
        push(3'd2, 8'h0, 1'b0);
        push(3'd3, ext ? {5'b11110, addr[9:8], 1'b1} : {addr[6:0], 1'b1}, 1'b0);
      end
      for (int k = 0; k < rxn; k++) push(3'd4, 8'h0, k == rxn - 1);
    end
    begin bit s = stopped; stopped = 0; push(3'd5, 8'h0, 1'b0); stopped = s; end
    check(log_n == en, {tag, " R2 command count"}, 64'(log_n), 64'(en));
    bad = 0;
    for (int i = 0; i < en && i < log_n; i++) begin
      if (log_cmd[i] !== exp_cmd[i] || log_lst[i] !== exp_lst[i] ||
          (exp_cmd[i] == 3'd3 && log_dat[i] !== exp_dat[i])) begin
        if (!bad) check(0, {tag, " R3 R4 R5 R6 command stream"},
                        {48'(i), 5'(log_cmd[i]), log_dat[i], log_lst[i], 2'b0},
                        {48'(i), 5'(exp_cmd[i]), exp_dat[i], exp_lst[i], 2'b0});
        bad = 1;
      end
    end
    if (!bad) check(1, {tag, " command stream"}, 0, 0);
    rd_reg(3'd5, d);
    check(d == {31'b0, stopped}, {tag, " R7 status error"}, 64'(d), 64'(stopped));
    rx_exp = '0;
    if (do_rd && !stopped) for (int k = 0; k < rxn; k++) rx_exp[8*k +: 8] = rx_seed + 8'(k) * 8'h29;
    rd_reg(3'd3, lo); rd_reg(3'd4, hi);
    check({hi, lo} == rx_exp, {tag, " R5 R10 receive words"}, {hi, lo}, rx_exp);
    rd_reg(3'd0, d);
    check(d == {11'b0, ctrl[20:0]}, {tag, " R9 R2 control retained"}, 64'(d), 64'(ctrl[20:0]));
    wr_reg(3'd6, 32'h0);
    rd_reg(3'd6, d);
    check(d == 0 && irq == 1'b0, {tag, " R8 cause cleared"}, {d, 31'b0, irq}, 64'd0);
    wr_reg(3'd0, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), d);
      check(d == 0, "R1 register reset", 64'(d), 64'd0);
    end
    check(irq == 0 && eng_req == 0, "R1 outputs idle", {irq, eng_req}, 0);
    // R9 no launch without enable
    wr_reg(3'd0, 32'hFFF7_FFFF);
    repeat (10) @(negedge clk);
    check(eng_req == 0, "R9 no start without enable", 64'(eng_req), 0);
    rd_reg(3'd0, d);
    check(d == 32'h0017_FFFF, "R9 R10 stored control", 64'(d), 64'h0017_FFFF);
    wr_reg(3'd0, 32'h0);
    rd_reg(3'd0, d);
    check(d == 0, "R9 control cleared", 64'(d), 0);
    wr_reg(3'd7, 32'h1);
    // R4 write only
    for (int n = 1; n <= 8; n++) run_xfer("R4", 1, 0, 0, 0, 10'(7'h50 + n), n, 1, -1, 8'(n * 17), 0);
    // R5 read only
    for (int n = 1; n <= 8; n++) run_xfer("R5", 0, 1, 0, 0, 10'(7'h21 + n), 1, n, -1, 8'(n * 29), 0);
    // R6 combined, all length pairs; R3 alternate 10-bit
    for (int t = 1; t <= 8; t++)
      for (int r = 1; r <= 8; r++)
        run_xfer("R6", 1, 1, 1, (t + r) % 3 == 0, 10'(t * 97 + r * 13), t, r, -1, 8'(t * 8 + r), 0);
    // R3 10-bit read only
    run_xfer("R3", 0, 1, 0, 1, 10'h2A5, 1, 4, -1, 8'h44, 0);
    // R6 no repeated start -> write only
    run_xfer("R6 nors", 1, 1, 0, 0, 10'h33, 3, 5, -1, 8'h71, 0);
    // R7 NACK at each write-type byte
    for (int k = 0; k < 5; k++) run_xfer("R7", 1, 1, 1, 0, 10'h48, 3, 2, k, 8'(k * 5 + 1), 0);
    run_xfer("R7 ext", 1, 0, 0, 1, 10'h1C3, 2, 1, 1, 8'h90, 0);
    // R2 writes while busy are ignored
    run_xfer("R2 busy", 1, 1, 1, 0, 10'h17, 8, 8, -1, 8'h3C, 1);
    // R8 masked completion
    mask_g = 1'b0;
    wr_reg(3'd7, 32'h0);
    run_xfer("R8 masked", 0, 1, 0, 0, 10'h62, 1, 2, -1, 8'h0F, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule